// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Host Loading

The block turns an 8-bit pixel code into a 24-bit RGB colour. It holds one table of colour entries for each of red, green and blue. A host fills the tables through a small register window that has only two live registers. One register sets a table pointer. The other is a data port that feeds red, green and blue in turn, under a component phase. After each blue byte the pointer moves to the next entry, so a host can stream a whole palette without rewriting the pointer.

Scanout logic sends pixel codes on a valid/ready stream and gets packed colours back on a second valid/ready stream, one register later. Whenever any colour byte is written, the block raises a one-cycle change pulse. The display side can use it to schedule a full-frame redraw.

**Back-pressure rules.** A pixel code is taken on a clock edge when `px_valid` and `px_ready` are both high. `px_ready` is high whenever the output register is empty or the consumer is taking its content that cycle. While `rgb_valid` is high and `rgb_ready` is low, `rgb_data` and `rgb_valid` hold their values.

Top module: `pal_dac`

## Requirements
- R1: After reset, every table entry reads back as zero through the lookup path, `rgb_valid`, `pal_changed` and `rd_ack` are low, the pointer is 0 and the phase is red.
- R2: A write to byte offset 0x0 (byte or word) loads `hw_data[7:0]` into the pointer and sets the phase to red (phase 0), whatever the phase was before.
- R3: A byte write (`hw_wide`=0) to offset 0x4 stores `hw_data[7:0]` into the component chosen by the phase (0 red, 1 green, 2 blue) at the current pointer, then advances the phase by one.
- R4: Storing a blue byte increments the pointer modulo 256 and returns the phase to red, so the byte after entry 255's blue goes to entry 0's red.
- R5: A word write (`hw_wide`=1) to offset 0x4 acts as four byte writes taken in the order bits 31:24, 23:16, 15:8, 7:0, each using and advancing the phase and pointer as in R3 and R4.
- R6: Writes to any offset other than 0x0 and 0x4 change no table entry, no pointer and no phase.
- R7: A host read (`rd_en`) is answered on the next cycle with `rd_ack` high and `rd_data` equal to zero.
- R8: A pixel code accepted at a clock edge produces, right after that edge, `rgb_valid`=1 and `rgb_data` = {red[code], green[code], blue[code]} in bits 23:16, 15:8 and 7:0.
- R9: The pixel streams follow the back-pressure rules above: while the output is stalled it holds its data and `px_ready` is low, and the output drains when `rgb_ready` returns.
- R10: A lookup accepted in the same cycle as a host write to the same entry returns the entry's old value. The next lookup of that entry returns the new value.
- R11: `pal_changed` is high for the cycle after each cycle with a write to offset 0x4, and low after cycles without one, including pointer writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 5 | Host write byte offset |
| hw_wide | input | 1 | 1 = 32-bit write, 0 = byte write |
| hw_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_ack | output | 1 | Read answer valid |
| rd_data | output | 32 | Read data (always zero) |
| px_valid | input | 1 | Pixel code valid |
| px_ready | output | 1 | Pixel code accepted when high with px_valid |
| px_idx | input | 8 | Pixel code |
| rgb_valid | output | 1 | Colour output valid |
| rgb_ready | input | 1 | Consumer takes colour |
| rgb_data | output | 24 | Packed colour {R,G,B} |
| pal_changed | output | 1 | One-cycle pulse after a palette byte write |

## Verification
The bench fills the whole table with word writes, starting from pointer 0. This runs the phase across word boundaries and wraps the pointer from 255 back to 0. Every entry is then swept through the lookup path and compared with an arithmetic pattern. A design that reversed the byte order of a word, or that reset the phase at each word, would show shifted colour components in the sweep. A design that missed the wrap would leave entry 0 wrong after later single writes.

Further directed cases cover these faults:
- A pointer write in the middle of a triple: a design that kept the old phase would write green instead of red.
- Writes to dead offsets: a design that decoded them would corrupt the table.
- A lookup that collides with a host write: a design that forwarded the write would return the new value one lookup early.
- A stalled output: a design that overwrote its register under back-pressure would lose a colour.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_RED = 2'd0;
  localparam phase_t PH_GRN = 2'd1;
  localparam phase_t PH_BLU = 2'd2;
  localparam int     NUM_COMP = 3;
  localparam int     COMP_W   = 8;

  function automatic phase_t phase_after(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 5,
  parameter int INDEX_OFS = 0,
  parameter int DATA_OFS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hw_en,
  input  logic [ADDR_W-1:0]             hw_addr,
  input  logic                          hw_wide,
  input  logic [COMP_W*LANES-1:0]       hw_data,
  output logic [LANES-1:0]              lane_en,
  output logic [LANES-1:0][1:0]         lane_ph,
  output logic [LANES-1:0][IDX_W-1:0]   lane_idx,
  output logic [LANES-1:0][COMP_W-1:0]  lane_byte,
  output logic                          data_wr
);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(INDEX_OFS);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(DATA_OFS);

  logic             idx_hit;
  logic [IDX_W-1:0] idx_q, idx_w, idx_d;
  phase_t           ph_q, ph_w, ph_d;

  assign idx_hit = hw_en && (hw_addr == A_INDEX);
  assign data_wr = hw_en && (hw_addr == A_DATA);

  // walk the lanes in order, most significant byte first
  always_comb begin
    idx_w = idx_q;
    ph_w  = ph_q;
    for (int k = 0; k < LANES; k++) begin
      lane_en[k]   = data_wr && (hw_wide || (k == 0));
      lane_byte[k] = hw_wide ? hw_data[COMP_W*(LANES-k)-1 -: COMP_W]
                             : hw_data[COMP_W-1:0];
      lane_idx[k]  = idx_w;
      lane_ph[k]   = ph_w;
      if (lane_en[k]) begin
        if (ph_w == PH_BLU) idx_w = idx_w + 1'b1;
        ph_w = phase_after(ph_w);
      end
    end
    if (idx_hit) begin
      idx_d = hw_data[IDX_W-1:0];
      ph_d  = PH_RED;
    end else begin
      idx_d = idx_w;
      ph_d  = ph_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hit |=> (ph_q == PH_RED) && (idx_q == $past(hw_data[IDX_W-1:0])));

  // R4
  blue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hw_wide && ph_q == PH_BLU)
      |=> (idx_q == $past(idx_q) + 1'b1) && (ph_q == PH_RED));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hw_wide && ph_q != PH_BLU)
      |=> (idx_q == $past(idx_q)) && (ph_q == $past(ph_q) + 2'd1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_hit || data_wr) |=> $stable(idx_q) && $stable(ph_q));
endmodule

// File: rtl/pal_dac_bank.sv
module pal_dac_bank
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LANES = 4,
  parameter int COMP  = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              lane_en,
  input  logic [LANES-1:0][1:0]         lane_ph,
  input  logic [LANES-1:0][IDX_W-1:0]   lane_idx,
  input  logic [LANES-1:0][COMP_W-1:0]  lane_byte,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [COMP_W-1:0]             rd_val
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam phase_t MY_PH = phase_t'(COMP);

  logic [COMP_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (lane_en[k] && lane_ph[k] == MY_PH)
          mem[lane_idx[k]] <= lane_byte[k];
    end
  end

  // read-before-write: the lookup sees the array as it was before this edge
  assign rd_val = mem[rd_idx];
endmodule

// File: rtl/pal_dac_pix.sv
module pal_dac_pix
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int RGB_W = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic [IDX_W-1:0]  px_idx,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [RGB_W-1:0]  rd_rgb,
  output logic              rgb_valid,
  input  logic              rgb_ready,
  output logic [RGB_W-1:0]  rgb_data
);
  assign px_ready = !rgb_valid || rgb_ready;
  assign rd_idx   = px_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb_data  <= '0;
    end else if (px_ready) begin
      rgb_valid <= px_valid;
      if (px_valid) rgb_data <= rd_rgb;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> rgb_valid && $stable(rgb_data));

  // R8
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |=> rgb_valid && (rgb_data == $past(rd_rgb)));
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 5,
  parameter int INDEX_OFS = 0,
  parameter int DATA_OFS  = 4,
  localparam int HW_W     = COMP_W * LANES,
  localparam int RGB_W    = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic              hw_wide,
  input  logic [HW_W-1:0]   hw_data,
  input  logic              rd_en,
  output logic              rd_ack,
  output logic [HW_W-1:0]   rd_data,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic [IDX_W-1:0]  px_idx,
  output logic              rgb_valid,
  input  logic              rgb_ready,
  output logic [RGB_W-1:0]  rgb_data,
  output logic              pal_changed
);
  logic [LANES-1:0]              lane_en;
  logic [LANES-1:0][1:0]         lane_ph;
  logic [LANES-1:0][IDX_W-1:0]   lane_idx;
  logic [LANES-1:0][COMP_W-1:0]  lane_byte;
  logic                          data_wr;
  logic [IDX_W-1:0]              rd_idx;
  logic [NUM_COMP-1:0][COMP_W-1:0] comp_val;
  logic [RGB_W-1:0]              rd_rgb;

  pal_dac_seq #(
    .IDX_W(IDX_W), .LANES(LANES), .ADDR_W(ADDR_W),
    .INDEX_OFS(INDEX_OFS), .DATA_OFS(DATA_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr),
    .hw_wide(hw_wide), .hw_data(hw_data), .lane_en(lane_en),
    .lane_ph(lane_ph), .lane_idx(lane_idx), .lane_byte(lane_byte),
    .data_wr(data_wr)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    pal_dac_bank #(.IDX_W(IDX_W), .LANES(LANES), .COMP(c)) u_bank (
      .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_ph(lane_ph),
      .lane_idx(lane_idx), .lane_byte(lane_byte), .rd_idx(rd_idx),
      .rd_val(comp_val[NUM_COMP-1-c])
    );
  end

  // red lands in the top byte, blue in the bottom byte
  assign rd_rgb = comp_val;

  pal_dac_pix #(.IDX_W(IDX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_ready(px_ready),
    .px_idx(px_idx), .rd_idx(rd_idx), .rd_rgb(rd_rgb),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pal_changed <= 1'b0;
      rd_ack      <= 1'b0;
    end else begin
      pal_changed <= data_wr;
      rd_ack      <= rd_en;
    end
  end

  assign rd_data = '0;

  // R11
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && hw_addr == ADDR_W'(DATA_OFS)) |=> pal_changed);

  // R11
  no_spurious_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en && hw_addr == ADDR_W'(DATA_OFS)) |=> !pal_changed);

  // R7
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack);
endmodule

// File: tb/pal_dac_bench.sv
`timescale 1ns/1ps
module pal_dac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [4:0]  hw_addr = '0;
  logic        hw_wide = 1'b0;
  logic [31:0] hw_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        px_valid = 1'b0;
  logic        px_ready;
  logic [7:0]  px_idx = '0;
  logic        rgb_valid;
  logic        rgb_ready = 1'b1;
  logic [23:0] rgb_data;
  logic        pal_changed;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_r [256];
  logic [7:0] exp_g [256];
  logic [7:0] exp_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  always #5 clk = ~clk;

  pal_dac u_pal_dac (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr),
    .hw_wide(hw_wide), .hw_data(hw_data), .rd_en(rd_en), .rd_ack(rd_ack),
    .rd_data(rd_data), .px_valid(px_valid), .px_ready(px_ready),
    .px_idx(px_idx), .rgb_valid(rgb_valid), .rgb_ready(rgb_ready),
    .rgb_data(rgb_data), .pal_changed(pal_changed)
  );

  function automatic logic [7:0] pat(int e, int c);
    return 8'((e * 7 + c * 85 + 3) ^ (e >> 2));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_byte(logic [7:0] b);
    case (m_ph)
      0: exp_r[m_idx] = b;
      1: exp_g[m_idx] = b;
      default: exp_b[m_idx] = b;
    endcase
    if (m_ph == 2) begin
      m_idx = m_idx + 8'd1;
      m_ph = 0;
    end else m_ph++;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic host_wr(logic [4:0] a, logic [31:0] d, bit wide);
    hw_en = 1'b1; hw_addr = a; hw_data = d; hw_wide = wide;
    @(negedge clk);
    hw_en = 1'b0;
    if (a == 5'd0) begin
      m_idx = d[7:0];
      m_ph = 0;
    end else if (a == 5'd4) begin
      if (wide) for (int k = 3; k >= 0; k--) model_byte(d[8*k +: 8]);
      else model_byte(d[7:0]);
    end
  endtask

  task automatic lookup(logic [7:0] e, string req);
    px_valid = 1'b1; px_idx = e;
    @(negedge clk);
    px_valid = 1'b0;
    chk(rgb_valid === 1'b1, req, 32'(rgb_valid), 32'd1);
    chk(rgb_data === {exp_r[e], exp_g[e], exp_b[e]}, req,
        32'(rgb_data), 32'({exp_r[e], exp_g[e], exp_b[e]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    for (int e = 0; e < 256; e++) begin
      exp_r[e] = '0; exp_g[e] = '0; exp_b[e] = '0;
    end
    m_idx = '0; m_ph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(rgb_valid === 1'b0 && pal_changed === 1'b0 && rd_ack === 1'b0, "R1",
        {29'd0, rgb_valid, pal_changed, rd_ack}, 32'd0);
    lookup(8'd0, "R1");
    lookup(8'd255, "R1");
    lookup(8'd77, "R1");

    // R5 + R4: fill whole table with word writes, wrapping back to entry 0
    host_wr(5'd0, 32'd0, 1'b0);
    for (int w = 0; w < 192; w++) begin
      logic [31:0] d;
      for (int k = 0; k < 4; k++) begin
        int n = 4 * w + k;
        d[31 - 8*k -: 8] = pat(n / 3, n % 3);
      end
      host_wr(5'd4, d, 1'b1);
    end
    chk(m_idx === 8'd0 && m_ph == 0, "R4 model wrap", 32'(m_idx), 32'd0);
    for (int e = 0; e < 256; e++) lookup(8'(e), "R5 sweep");

    // R4: after the full wrap the next byte lands in entry 0 red
    host_wr(5'd4, 32'h0000_00A5, 1'b0);
    lookup(8'd0, "R4 wrap to 0");

    // R3 + R4: byte writes around the top of the table
    host_wr(5'd0, 32'd254, 1'b0);
    for (int n = 0; n < 9; n++) host_wr(5'd4, 32'(8'(n * 29 + 1)), 1'b0);
    lookup(8'd254, "R3");
    lookup(8'd255, "R4");
    lookup(8'd0, "R4");
    lookup(8'd1, "R3");

    // R2: pointer write in mid-triple resets phase to red
    host_wr(5'd0, 32'd10, 1'b0);
    host_wr(5'd4, 32'h11, 1'b0);
    host_wr(5'd4, 32'h22, 1'b0);
    host_wr(5'd0, 32'hFFFF_FF14, 1'b1);
    host_wr(5'd4, 32'h33, 1'b0);
    lookup(8'd10, "R2");
    lookup(8'd20, "R2");

    // R6: dead offsets are ignored, sequence continues where it was
    host_wr(5'd16, 32'hDEAD_BEEF, 1'b1);
    host_wr(5'd1, 32'h0000_0099, 1'b0);
    host_wr(5'd8, 32'h0000_0077, 1'b0);
    host_wr(5'd4, 32'h44, 1'b0);
    lookup(8'd20, "R6");
    lookup(8'd21, "R6");

    // R11: change pulse after data write, none after pointer write
    hw_en = 1'b1; hw_addr = 5'd4; hw_data = 32'h55; hw_wide = 1'b0;
    @(negedge clk);
    hw_en = 1'b0; model_byte(8'h55);
    chk(pal_changed === 1'b1, "R11 pulse", 32'(pal_changed), 32'd1);
    @(negedge clk);
    chk(pal_changed === 1'b0, "R11 one cycle", 32'(pal_changed), 32'd0);
    host_wr(5'd0, 32'd30, 1'b0);
    chk(pal_changed === 1'b0, "R11 index", 32'(pal_changed), 32'd0);

    // R7: reads answer zero one cycle later
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_ack === 1'b1 && rd_data === 32'd0, "R7", rd_data, 32'd0);
    @(negedge clk);
    chk(rd_ack === 1'b0, "R7 single", 32'(rd_ack), 32'd0);

    // R10: collision of lookup and write to entry 30 red
    held = {exp_r[30], exp_g[30], exp_b[30]};
    hw_en = 1'b1; hw_addr = 5'd4; hw_data = 32'hEE; hw_wide = 1'b0;
    px_valid = 1'b1; px_idx = 8'd30;
    @(negedge clk);
    hw_en = 1'b0; px_valid = 1'b0;
    chk(rgb_data === held, "R10 old", 32'(rgb_data), 32'(held));
    model_byte(8'hEE);
    lookup(8'd30, "R10 new");

    // R8: output empties when nothing new is offered
    @(negedge clk);
    chk(rgb_valid === 1'b0, "R8 drain", 32'(rgb_valid), 32'd0);

    // R9: back-pressure
    rgb_ready = 1'b0;
    px_valid = 1'b1; px_idx = 8'd100;
    @(negedge clk);
    held = {exp_r[100], exp_g[100], exp_b[100]};
    chk(px_ready === 1'b0, "R9 ready low", 32'(px_ready), 32'd0);
    px_idx = 8'd101;
    repeat (3) @(negedge clk);
    chk(rgb_valid === 1'b1 && rgb_data === held, "R9 hold", 32'(rgb_data), 32'(held));
    rgb_ready = 1'b1;
    @(negedge clk);
    px_valid = 1'b0;
    chk(rgb_data === {exp_r[101], exp_g[101], exp_b[101]}, "R9 resume",
        32'(rgb_data), 32'({exp_r[101], exp_g[101], exp_b[101]}));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule